// File: doc/BRIEF.md
# Four-Channel Digital Potentiometer Wiper Bank

This block keeps the control state of four digital potentiometers. Each channel owns one live wiper position, which selects a single tap switch out of 256, and four stored preset values that model retained memory. A serial front end, outside this block, turns bus transactions into one-cycle commands. A command can set the wiper directly, store a preset, read the wiper or a preset, or load a preset into the wiper.

The synchronous active-low reset acts as the power-up recall: every channel's wiper takes the value of its preset 0. The preset flops themselves are never cleared. A write-protect input, active low, refuses preset stores only. A refused store changes nothing and raises an error pulse. An accepted store holds a busy flag for a fixed programming window. While that window is open, every command is dropped without a response.

Top module: `pot_bank_top`

## Requirements
- R1: The block has four independent channels. A command addressed to channel `cmd_chan` never changes the wiper or presets of any other channel. Wiper c is visible on `wiper_pos[c*8 +: 8]`.
- R2: For every channel c, `tap_sel[c*256 +: 256]` has exactly one bit set, and that bit's index equals the channel's wiper value.
- R3: A clock edge with `rst_n` low loads each channel's wiper from its preset 0 and clears `busy`, `rd_valid` and `err_pulse`. Preset contents are kept through reset.
- R4: Op code 1 writes `cmd_wdata` into the addressed wiper. It works whatever the level of `wp_n`.
- R5: Op code 2 with `wp_n` low is refused. No register changes, `busy` stays low, and `err_pulse` is high for exactly the one cycle after the command edge.
- R6: Op code 3 returns the addressed wiper and op code 4 returns preset `cmd_sel`. Either one gives `rd_valid` high for one cycle after the command edge, with the value on `rd_data`.
- R7: Op code 5 copies preset `cmd_sel` of the addressed channel into its wiper.
- R8: Op code 2 with `wp_n` high stores `cmd_wdata` into preset `cmd_sel`. `busy` is then high for exactly PROG_CYCLES (default 16) cycles, starting the cycle after the command edge.
- R9: A command presented while `busy` is high is ignored. It produces no register change, no read response and no error.
- R10: `tap_sel` follows a wiper change one clock edge later than `wiper_pos`.
- R11: Op codes 0, 6 and 7 have no effect on any register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset and preset-0 recall |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Op code: 0 none, 1 set wiper, 2 store preset, 3 read wiper, 4 read preset, 5 load preset |
| cmd_chan | input | 2 | Channel addressed |
| cmd_sel | input | 2 | Preset index |
| cmd_wdata | input | 8 | Write value |
| wp_n | input | 1 | Low refuses preset stores |
| busy | output | 1 | Preset programming window open |
| err_pulse | output | 1 | One-cycle pulse for a refused store |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 8 | Read response value |
| wiper_pos | output | 32 | Wiper values of all four channels |
| tap_sel | output | 1024 | One-hot tap selects, 256 per channel |

## Verification
Suppose a command is sampled on edge k. Then `wiper_pos`, `rd_valid`/`rd_data`, `err_pulse` and the first cycle of `busy` are all due just after edge k, and `tap_sel` is due one edge later. The bench drives on falling edges and holds a command for one cycle. It checks wipers and the error flag at the next falling edge, and it checks that `tap_sel` still shows the old tap at that falling edge and the new one at the falling edge after. Read responses are queued when they are issued and popped by a monitor, which flags any response that arrives without a matching entry.

// File: rtl/pot_bank_pkg.sv
// Package: op codes and the decoded action shared by the wiper bank modules.
package pot_bank_pkg;
    localparam logic [2:0] OP_NOP          = 3'd0;
    localparam logic [2:0] OP_SET_WIPER    = 3'd1;
    localparam logic [2:0] OP_STORE_PRESET = 3'd2;
    localparam logic [2:0] OP_READ_WIPER   = 3'd3;
    localparam logic [2:0] OP_READ_PRESET  = 3'd4;
    localparam logic [2:0] OP_LOAD_PRESET  = 3'd5;

    typedef struct packed {
        logic set_wiper;
        logic store_preset;
        logic load_preset;
        logic read_wiper;
        logic read_preset;
        logic refused;
    } pot_action_t;
endpackage

// File: rtl/pot_cmd_decode.sv
// Module: pot_cmd_decode
// Turns one raw command into a set of action strobes. Applies the busy
// lockout and the write protect.
// Assumes: at most one command per cycle; unknown op codes decode to nothing.
module pot_cmd_decode
    import pot_bank_pkg::*;
(
    input  logic        cmd_valid,
    input  logic [2:0]  cmd_op,
    input  logic        busy,
    input  logic        wp_n,
    output pot_action_t act
);
    logic live;

    // Decode the op code into strobes, gated by busy and write protect.
    always_comb begin
        act  = '0;
        live = cmd_valid && !busy;
        if (live) begin
            unique case (cmd_op)
                OP_SET_WIPER:    act.set_wiper   = 1'b1;
                OP_STORE_PRESET: begin
                    act.store_preset = wp_n;
                    act.refused      = !wp_n;
                end
                OP_READ_WIPER:   act.read_wiper  = 1'b1;
                OP_READ_PRESET:  act.read_preset = 1'b1;
                OP_LOAD_PRESET:  act.load_preset = 1'b1;
                default:         act = '0;
            endcase
        end
    end
endmodule

// File: rtl/pot_prog_timer.sv
// Module: pot_prog_timer
// Holds busy for PROG_CYCLES cycles after an accepted preset store. This
// stands in for the programming time of retained memory.
// Assumes: start only arrives while busy is low.
module pot_prog_timer #(
    parameter int PROG_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(PROG_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(PROG_CYCLES);

    logic [CW-1:0] remain;

    // Load the window on start and count it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (start)
            remain <= LOAD;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/pot_channel.sv
// Module: pot_channel
// State of one potentiometer: a live wiper and NPRESET stored presets.
// Reset recalls preset 0 into the wiper. Presets have no reset so that
// they keep their values, as retained memory would.
// Assumes: the strobes in act are already qualified by channel match.
module pot_channel
    import pot_bank_pkg::*;
#(
    parameter int DW      = 8,
    parameter int NPRESET = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  pot_action_t                act,
    input  logic [$clog2(NPRESET)-1:0] idx,
    input  logic [DW-1:0]              wdata,
    output logic [DW-1:0]              wiper,
    output logic [DW-1:0]              preset_rd
);
    logic [DW-1:0] preset [NPRESET];

    for (genvar i = 0; i < NPRESET; i++) begin : g_preset
        // Store one preset slot when it is addressed by an accepted store.
        always_ff @(posedge clk) begin
            if (act.store_preset && (idx == i))
                preset[i] <= wdata;
        end
    end

    // Wiper register: recall on reset, else a direct write or a preset load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wiper <= preset[0];
        else if (act.set_wiper)
            wiper <= wdata;
        else if (act.load_preset)
            wiper <= preset[idx];
    end

    assign preset_rd = preset[idx];
endmodule

// File: rtl/pot_tap_decoder.sv
// Module: pot_tap_decoder
// Registered one-hot decode of a wiper value into 2**DW tap selects.
// Assumes: every DW-bit value maps to a real tap. The register has no reset
// because its input always decodes to a single tap.
module pot_tap_decoder #(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic [DW-1:0]     wiper,
    output logic [(1<<DW)-1:0] taps
);
    localparam int NTAP = 1 << DW;

    // Register the one-hot select so the switch drive changes on a clean edge.
    always_ff @(posedge clk) begin
        taps <= NTAP'(1) << wiper;
    end
endmodule

// File: rtl/pot_bank_top.sv
// Module: pot_bank_top
// Bank of NCH potentiometer channels behind one command port. It decodes
// commands, routes the strobes to the addressed channel, times preset
// programming, returns read data and drives the one-hot tap selects.
// Assumes: commands last one cycle; rst_n low for at least one edge at power-up.
module pot_bank_top
    import pot_bank_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int DW          = 8,
    parameter int NPRESET     = 4,
    parameter int PROG_CYCLES = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_valid,
    input  logic [2:0]                   cmd_op,
    input  logic [$clog2(NCH)-1:0]       cmd_chan,
    input  logic [$clog2(NPRESET)-1:0]   cmd_sel,
    input  logic [DW-1:0]                cmd_wdata,
    input  logic                         wp_n,
    output logic                         busy,
    output logic                         err_pulse,
    output logic                         rd_valid,
    output logic [DW-1:0]                rd_data,
    output logic [NCH*DW-1:0]            wiper_pos,
    output logic [NCH*(1<<DW)-1:0]       tap_sel
);
    localparam int NTAP = 1 << DW;

    pot_action_t   act;
    logic [DW-1:0] wiper_arr  [NCH];
    logic [DW-1:0] preset_arr [NCH];

    pot_cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .busy      (busy),
        .wp_n      (wp_n),
        .act       (act)
    );

    pot_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (act.store_preset),
        .busy  (busy)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        pot_action_t ch_act;

        // Pass the strobes only to the addressed channel.
        always_comb begin
            ch_act = (cmd_chan == c) ? act : '0;
        end

        pot_channel #(.DW(DW), .NPRESET(NPRESET)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .act       (ch_act),
            .idx       (cmd_sel),
            .wdata     (cmd_wdata),
            .wiper     (wiper_arr[c]),
            .preset_rd (preset_arr[c])
        );

        pot_tap_decoder #(.DW(DW)) u_taps (
            .clk   (clk),
            .wiper (wiper_arr[c]),
            .taps  (tap_sel[c*NTAP +: NTAP])
        );

        assign wiper_pos[c*DW +: DW] = wiper_arr[c];
    end

    // Register the read response and the refusal pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            err_pulse <= 1'b0;
        end else begin
            rd_valid  <= act.read_wiper || act.read_preset;
            err_pulse <= act.refused;
            if (act.read_wiper)
                rd_data <= wiper_arr[cmd_chan];
            else if (act.read_preset)
                rd_data <= preset_arr[cmd_chan];
        end
    end
endmodule

// File: rtl/pot_bank_chk.sv
// Module: pot_bank_chk
// Property checker for pot_bank_top, attached by bind.
module pot_bank_chk
    import pot_bank_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cmd_valid,
    input logic [2:0]             cmd_op,
    input logic                   wp_n,
    input logic                   busy,
    input logic                   err_pulse,
    input logic                   rd_valid,
    input logic [NCH*DW-1:0]      wiper_pos,
    input logic [NCH*(1<<DW)-1:0] tap_sel
);
    localparam int NTAP = 1 << DW;

    logic [NCH*DW-1:0] wiper_d;

    // Keep the wiper values of the previous edge for the tap check.
    always_ff @(posedge clk) wiper_d <= wiper_pos;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot(tap_sel[c*NTAP +: NTAP])); // R2
        AST_TAP_LAGS_WIPER: assert property (@(posedge clk) disable iff (!rst_n)
            tap_sel[c*NTAP + int'(wiper_d[c*DW +: DW])]); // R10
    end

    AST_ERR_FROM_REFUSAL: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(cmd_valid && !busy && cmd_op == OP_STORE_PRESET && !wp_n)); // R5
    AST_READ_FROM_READ_OP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(cmd_valid && !busy
                           && (cmd_op == OP_READ_WIPER || cmd_op == OP_READ_PRESET))); // R6
    AST_BUSY_FROM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid && cmd_op == OP_STORE_PRESET && wp_n)); // R8
    AST_BUSY_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> (!rd_valid && !err_pulse && $stable(wiper_pos))); // R9
    AST_IDLE_KEEPS_WIPER: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(wiper_pos)); // R1
endmodule

bind pot_bank_top pot_bank_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .wp_n      (wp_n),
    .busy      (busy),
    .err_pulse (err_pulse),
    .rd_valid  (rd_valid),
    .wiper_pos (wiper_pos),
    .tap_sel   (tap_sel)
);

// File: tb/tb_pot_bank_top.sv
// Scoreboard bench: the driver queues expected read data, a monitor pops it.
module tb_pot_bank_top;
    localparam int PROG = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [2:0]   cmd_op = '0;
    logic [1:0]   cmd_chan = '0;
    logic [1:0]   cmd_sel = '0;
    logic [7:0]   cmd_wdata = '0;
    logic         wp_n = 1'b1;
    logic         busy, err_pulse, rd_valid;
    logic [7:0]   rd_data;
    logic [31:0]  wiper_pos;
    logic [1023:0] tap_sel;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    bit known = 0;
    logic [7:0] m_w [4];
    logic [7:0] m_p [4][4];
    logic [7:0] rdq [$];

    always #4 clk = ~clk;

    pot_bank_top #(.PROG_CYCLES(PROG)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_chan(cmd_chan), .cmd_sel(cmd_sel), .cmd_wdata(cmd_wdata),
        .wp_n(wp_n), .busy(busy), .err_pulse(err_pulse), .rd_valid(rd_valid),
        .rd_data(rd_data), .wiper_pos(wiper_pos), .tap_sel(tap_sel)
    );

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Compare every wiper against the model (channel isolation).
    task automatic check_wipers(string req);
        for (int c = 0; c < 4; c++)
            chk(wiper_pos[c*8 +: 8] == m_w[c], req, "wiper", int'(wiper_pos[c*8 +: 8]), int'(m_w[c]));
    endtask

    task automatic check_tap(int c, logic [7:0] v, string req);
        int ones;
        ones = $countones(tap_sel[c*256 +: 256]);
        chk(ones == 1 && tap_sel[c*256 + int'(v)], req, "tap", ones, int'(v));
    endtask

    // Drive one command; accepted says whether it should take effect.
    task automatic issue(logic [2:0] op, int ch, int sel, logic [7:0] d, bit accepted);
        bit refuse;
        refuse = accepted && op == 3'd2 && !wp_n;
        @(negedge clk);
        cmd_op = op; cmd_chan = 2'(ch); cmd_sel = 2'(sel); cmd_wdata = d; cmd_valid = 1'b1;
        if (accepted && op == 3'd3) rdq.push_back(m_w[ch]);
        if (accepted && op == 3'd4) rdq.push_back(m_p[ch][sel]);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (accepted && !refuse) begin
            case (op)
                3'd1: m_w[ch] = d;
                3'd2: m_p[ch][sel] = d;
                3'd5: m_w[ch] = m_p[ch][sel];
                default: ;
            endcase
        end
        chk(err_pulse == refuse, "R5", "err_pulse", int'(err_pulse), int'(refuse));
        if (known) check_wipers("R1");
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    // Monitor: pop one expected read per response.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (rdq.size() == 0)
                chk(0, "R9", "unexpected read response", int'(rd_data), 0);
            else begin
                logic [7:0] e;
                e = rdq.pop_front();
                chk(rd_data == e, "R6", "rd_data", int'(rd_data), int'(e));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "R1", "watchdog expired", 0, 1);
        report();
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !rd_valid && !err_pulse, "R3", "idle after reset",
            int'({busy, rd_valid, err_pulse}), 0);

        // R8: store all presets with write enable, time the busy window once.
        for (int c = 0; c < 4; c++)
            for (int s = 0; s < 4; s++) begin
                issue(3'd2, c, s, 8'(c*64 + s*16 + 5), 1);
                if (c == 0 && s == 0) begin
                    cnt = 0;
                    while (busy) begin cnt++; @(negedge clk); end
                    chk(cnt == PROG, "R8", "busy length", cnt, PROG);
                end
                wait_idle();
            end
        m_p[3][0] = 8'hFF;
        issue(3'd2, 3, 0, 8'hFF, 1);
        wait_idle();
        for (int c = 0; c < 4; c++)
            for (int s = 0; s < 4; s++) issue(3'd4, c, s, 0, 1); // R6

        // R3: recall preset 0 into every wiper; presets survive.
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        for (int c = 0; c < 4; c++) m_w[c] = m_p[c][0];
        known = 1;
        check_wipers("R3");
        for (int c = 0; c < 4; c++) check_tap(c, m_w[c], "R2");
        issue(3'd4, 2, 3, 0, 1); // R3 preset kept
        issue(3'd3, 3, 0, 0, 1); // R6 wiper read

        // R4: direct write under write protect, then tap lag R10.
        wp_n = 1'b0;
        issue(3'd1, 2, 0, 8'hFF, 1);
        check_tap(2, m_p[2][0], "R10");
        @(negedge clk);
        check_tap(2, 8'hFF, "R10");
        issue(3'd1, 1, 0, 8'h00, 1);
        @(negedge clk);
        check_tap(1, 8'h00, "R2");

        // R5: refused store changes nothing, no busy.
        issue(3'd2, 0, 1, 8'hAA, 1);
        chk(!busy, "R5", "busy after refusal", int'(busy), 0);
        issue(3'd4, 0, 1, 0, 1);
        wp_n = 1'b1;

        // R7: load preset 3 of channel 1 into its wiper.
        issue(3'd5, 1, 3, 0, 1);
        @(negedge clk);
        check_tap(1, m_w[1], "R7");

        // R9: commands during busy are dropped.
        issue(3'd2, 0, 2, 8'h3C, 1);
        issue(3'd1, 0, 0, 8'h77, 0);
        issue(3'd3, 1, 0, 0, 0);
        issue(3'd5, 2, 1, 0, 0);
        wp_n = 1'b0;
        issue(3'd2, 1, 1, 8'h12, 0);
        wp_n = 1'b1;
        wait_idle();
        issue(3'd4, 0, 2, 0, 1);
        issue(3'd4, 1, 1, 0, 1);

        // R11: unused op codes.
        issue(3'd0, 0, 0, 8'h55, 1);
        issue(3'd6, 1, 2, 8'h55, 1);
        issue(3'd7, 2, 3, 8'h55, 1);
        chk(!busy && !rd_valid, "R11", "no response", int'({busy, rd_valid}), 0);

        repeat (3) @(negedge clk);
        chk(rdq.size() == 0, "R6", "reads outstanding", rdq.size(), 0);
        report();
    end
endmodule